// File: doc/BRIEF.md
# Reset Source Collector and System Options Controller

This block gathers every reason a microcontroller may need to restart and turns them into one system reset output. Requests come from power-on, a low-voltage detector, the watchdog, the instruction decoder (undefined opcodes, and stop or background instructions executed while they are not permitted), a clock-loss monitor and a debug host. Some requests are qualified by configuration enables. Any qualified request starts a reset, and the reset output is stretched to a fixed length after the last qualified request. A read-only status register records which sources caused the most recent reset.

The block also holds two registers. The first is a force-reset register that only the debug port can write. The second is a system options register that software may write once after each reset. This register supplies the watchdog, stop and low-voltage reset enables used by the qualification logic. Software reads and writes the registers over a small register bus with an address, read and write strobes, and byte-wide data. The debug host uses its own write path.

Top module: `sysrst_hub`

## Requirements
- R1: While `pwr_on_rst_n` is low, `sys_rst` is 1, status reads 0x03 (power-on bit 0 and low-voltage bit 1 both set) and options read 0xB0. After release, `sys_rst` stays 1 for 16 more cycles.
- R2: `sys_rst` rises on the clock edge that samples a qualified request. It stays 1 for exactly 16 clock cycles after the last qualified request, so a request arriving during an active reset extends the reset.
- R3: Status register address is 0. Flag positions are power-on 0, low-voltage 1, watchdog 2, illegal opcode 3, clock loss 4, debug-forced 5. On a reset that starts from idle, status becomes exactly the set of sources qualified in that cycle, with simultaneous sources captured together. Sources qualified while a reset is already active are OR-ed in. Bus writes never change the status register.
- R4: Options bit 7 enables the watchdog reset and bit 4 enables the low-voltage reset. A watchdog request or low-voltage request with its enable at 0 causes no reset and leaves the status register unchanged.
- R5: An illegal-opcode reset is caused by `illop_req`, by `stop_exec` when options bit 5 (stop enable) is 0, or by `bgnd_exec` when `dbg_ena` is 0. A stop instruction with stop enabled, or a background instruction with `dbg_ena` at 1, has no effect.
- R6: The force-reset register is at address 1 and always reads 0x00. A debug-port write with data bit 0 at 1 forces a reset. A debug-port write with bit 0 at 0, or any bus write to address 1, has no effect.
- R7: The options register is at address 2 and can be read at any time. Bits 3 and 2 always read 0. Only the first bus write after a reset is stored, and later writes are ignored.
- R8: Every system reset returns the options register to 0xB0 and permits one new write.
- R9: Bus writes are ignored while `sys_rst` is 1. `bus_rdata` is 0 when `bus_rd` is 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_on_rst_n | input | 1 | Power-on reset, asynchronous, active low |
| lvd_req | input | 1 | Low-voltage detector trip |
| wdog_req | input | 1 | Watchdog timeout |
| illop_req | input | 1 | Undefined opcode executed |
| stop_exec | input | 1 | Stop instruction executed |
| bgnd_exec | input | 1 | Background instruction executed |
| clkloss_req | input | 1 | External clock lost |
| dbg_ena | input | 1 | Active debug mode permitted |
| bus_addr | input | 2 | Register bus address |
| bus_rd | input | 1 | Register bus read strobe |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |
| dbg_wr | input | 1 | Debug-port write strobe to the force-reset register |
| dbg_wdata | input | 8 | Debug-port write data |
| sys_rst | output | 1 | Stretched system reset, active high |

## Verification
The hardest cases to reach are those where a source is masked by an enable or is legal. To test them, the options register must first hold a chosen configuration, and each such write closes the register until the next reset. The stimulus therefore forces a reset through the debug port before each trial, which reopens the write. It then writes one of the eight enable combinations and pulses a single source. This sweeps every source against every configuration, and the bench predicts from the enables whether a reset, a status change and an options restore should follow. A separate sequence injects a second source partway through an active reset to show the extension and the OR-ed status flags.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned NUM_SRC = 6;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STAT  = 2'd0,
        ADDR_FORCE = 2'd1,
        ADDR_OPT   = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    // Status flag positions
    localparam int unsigned SRC_POR   = 0;
    localparam int unsigned SRC_LVD   = 1;
    localparam int unsigned SRC_WDOG  = 2;
    localparam int unsigned SRC_ILLOP = 3;
    localparam int unsigned SRC_CLK   = 4;
    localparam int unsigned SRC_DBG   = 5;

    // Option bit positions
    localparam int unsigned OPT_WDOG_EN = 7;
    localparam int unsigned OPT_STOP_EN = 5;
    localparam int unsigned OPT_LVD_EN  = 4;

    localparam logic [DATA_W-1:0] OPT_DEFAULT   = 8'hB0;
    localparam logic [DATA_W-1:0] OPT_IMPL_MASK = 8'hF3;
    localparam logic [DATA_W-1:0] STAT_POWERUP  = 8'h03;

    typedef struct packed {
        logic wdog_en;
        logic stop_en;
        logic lvd_en;
    } opt_view_t;

endpackage

// File: rtl/sysrst_qualify.sv
module sysrst_qualify
    import sysrst_pkg::*;
(
    input  opt_view_t          opt,
    input  logic               dbg_ena,
    input  logic               lvd_req,
    input  logic               wdog_req,
    input  logic               illop_req,
    input  logic               stop_exec,
    input  logic               bgnd_exec,
    input  logic               clkloss_req,
    input  logic               dbg_force,
    output logic [NUM_SRC-1:0] src_evt
);

    logic illegal_stop;
    logic illegal_bgnd;

    always_comb begin
        illegal_stop = stop_exec & ~opt.stop_en;
        illegal_bgnd = bgnd_exec & ~dbg_ena;

        src_evt            = '0;
        src_evt[SRC_POR]   = 1'b0;   // power-on only via asynchronous reset
        src_evt[SRC_LVD]   = lvd_req & opt.lvd_en;
        src_evt[SRC_WDOG]  = wdog_req & opt.wdog_en;
        src_evt[SRC_ILLOP] = illop_req | illegal_stop | illegal_bgnd;
        src_evt[SRC_CLK]   = clkloss_req;
        src_evt[SRC_DBG]   = dbg_force;
    end

endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
    parameter int unsigned STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic pwr_on_rst_n,
    input  logic trig,
    output logic rst_active
);

    localparam int unsigned CNT_W = $clog2(STRETCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } stretch_t;

    stretch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.cnt = CNT_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge pwr_on_rst_n) begin
        if (!pwr_on_rst_n) begin
            st_q.cnt <= CNT_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_active = (st_q.cnt != '0);

    // R2: a qualified request always leaves the reset asserted
    a_r2_trig_asserts: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        trig |=> rst_active);

    // R2: reset may only end after a quiet cycle
    a_r2_release_quiet: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        $fell(rst_active) |-> $past(!trig));

endmodule

// File: rtl/sysrst_regs.sv
module sysrst_regs
    import sysrst_pkg::*;
(
    input  logic               clk,
    input  logic               pwr_on_rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               rst_active,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output opt_view_t          opt_view
);

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] opt;
        logic              lock;
    } regs_t;

    regs_t rg_d, rg_q;

    logic              any_evt;
    logic [DATA_W-1:0] evt_byte;
    logic              opt_wr;

    always_comb begin
        any_evt  = |src_evt;
        evt_byte = DATA_W'(src_evt);
        opt_wr   = bus_wr && (bus_addr == ADDR_OPT) && !rg_q.lock && !rst_active;

        rg_d = rg_q;
        if (any_evt) begin
            rg_d.stat = rst_active ? (rg_q.stat | evt_byte) : evt_byte;
            rg_d.opt  = OPT_DEFAULT;
            rg_d.lock = 1'b0;
        end else if (rst_active) begin
            rg_d.opt  = OPT_DEFAULT;
            rg_d.lock = 1'b0;
        end else if (opt_wr) begin
            rg_d.opt  = bus_wdata & OPT_IMPL_MASK;
            rg_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pwr_on_rst_n) begin
        if (!pwr_on_rst_n) begin
            rg_q.stat <= STAT_POWERUP;
            rg_q.opt  <= OPT_DEFAULT;
            rg_q.lock <= 1'b0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_STAT: bus_rdata = rg_q.stat;
                ADDR_OPT:  bus_rdata = rg_q.opt;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign opt_view.wdog_en = rg_q.opt[OPT_WDOG_EN];
    assign opt_view.stop_en = rg_q.opt[OPT_STOP_EN];
    assign opt_view.lvd_en  = rg_q.opt[OPT_LVD_EN];

    // R3: status only moves on a qualified request
    a_r3_stat_hold: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        !any_evt |=> $stable(rg_q.stat));

    // R7: once written, options stay put until a reset
    a_r7_write_once: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        (rg_q.lock && !any_evt && !rst_active) |=> $stable(rg_q.opt));

    // R7: unimplemented option bits stay clear
    a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        rg_q.opt[3:2] == 2'b00);

    // R8: during a system reset options sit at default and unlocked
    a_r8_default_in_reset: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        rst_active |-> (rg_q.opt == OPT_DEFAULT && !rg_q.lock));

    // R9: idle read bus is zero
    a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
    import sysrst_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 16
) (
    input  logic              clk,
    input  logic              pwr_on_rst_n,
    input  logic              lvd_req,
    input  logic              wdog_req,
    input  logic              illop_req,
    input  logic              stop_exec,
    input  logic              bgnd_exec,
    input  logic              clkloss_req,
    input  logic              dbg_ena,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              dbg_wr,
    input  logic [7:0]        dbg_wdata,
    output logic              sys_rst
);

    opt_view_t          opt_view;
    logic [NUM_SRC-1:0] src_evt;
    logic               dbg_force;
    logic               rst_active;

    assign dbg_force = dbg_wr & dbg_wdata[0];

    sysrst_qualify u_qualify (
        .opt         (opt_view),
        .dbg_ena     (dbg_ena),
        .lvd_req     (lvd_req),
        .wdog_req    (wdog_req),
        .illop_req   (illop_req),
        .stop_exec   (stop_exec),
        .bgnd_exec   (bgnd_exec),
        .clkloss_req (clkloss_req),
        .dbg_force   (dbg_force),
        .src_evt     (src_evt)
    );

    sysrst_stretch #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_stretch (
        .clk          (clk),
        .pwr_on_rst_n (pwr_on_rst_n),
        .trig         (|src_evt),
        .rst_active   (rst_active)
    );

    sysrst_regs u_regs (
        .clk          (clk),
        .pwr_on_rst_n (pwr_on_rst_n),
        .src_evt      (src_evt),
        .rst_active   (rst_active),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .opt_view     (opt_view)
    );

    assign sys_rst = rst_active;

    // R6: the force-reset register always reads zero
    a_r6_force_reads_zero: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        (bus_rd && bus_addr == ADDR_FORCE) |-> (bus_rdata == 8'h00));

    // R6: a debug force always yields a reset with its flag
    a_r6_dbg_forces: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
        (dbg_wr && dbg_wdata[0]) |=> sys_rst);

endmodule

// File: tb/sysrst_hub_bench.sv
module sysrst_hub_bench;

    localparam int STRETCH = 16;

    logic       clk = 1'b0;
    logic       pwr_on_rst_n = 1'b0;
    logic       lvd_req = 0, wdog_req = 0, illop_req = 0, stop_exec = 0;
    logic       bgnd_exec = 0, clkloss_req = 0, dbg_ena = 0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 0, bus_wr = 0, dbg_wr = 0;
    logic [7:0] bus_wdata = 8'h00, dbg_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sys_rst;

    int checks = 0;
    int failures = 0;
    logic [7:0] v;
    int n;

    always #4 clk = ~clk;

    sysrst_hub #(.STRETCH_CYC(STRETCH)) u_sysrst_hub (
        .clk(clk), .pwr_on_rst_n(pwr_on_rst_n),
        .lvd_req(lvd_req), .wdog_req(wdog_req), .illop_req(illop_req),
        .stop_exec(stop_exec), .bgnd_exec(bgnd_exec), .clkloss_req(clkloss_req),
        .dbg_ena(dbg_ena), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .sys_rst(sys_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] val);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 val = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic dbgw(input logic [7:0] d);
        @(negedge clk);
        dbg_wdata = d; dbg_wr = 1'b1;
        @(negedge clk);
        dbg_wr = 1'b0;
    endtask

    // counts cycles of sys_rst starting at the current negedge
    task automatic count_rst(output int cnt);
        cnt = 0;
        while (sys_rst === 1'b1 && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic set_src(input int s, input logic val);
        case (s)
            0: illop_req = val;
            1: stop_exec = val;
            2, 3: bgnd_exec = val;
            4: wdog_req = val;
            5: lvd_req = val;
            6: clkloss_req = val;
            default: begin dbg_wr = val; dbg_wdata = {7'd0, val}; end
        endcase
    endtask

    task automatic pulse_src(input int s);
        @(negedge clk);
        set_src(s, 1'b1);
        @(negedge clk);
        set_src(s, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: power-on state
        #20;
        check("R1 sys_rst during power-on", sys_rst, 1);
        bus_addr = 2'd0; bus_rd = 1'b1;
        #1 check("R1 status during power-on", bus_rdata, 8'h03);
        bus_rd = 1'b0;
        @(negedge clk);
        pwr_on_rst_n = 1'b1;
        count_rst(n);
        check("R1 stretch after power-on", n, STRETCH);
        rd(2'd0, v); check("R1 status after power-on", v, 8'h03);
        rd(2'd2, v); check("R1 options default", v, 8'hB0);

        // R9 / R6: read map
        rd(2'd1, v); check("R6 force reads zero", v, 8'h00);
        rd(2'd3, v); check("R9 unmapped reads zero", v, 8'h00);
        @(negedge clk); bus_addr = 2'd0; #1 check("R9 idle rdata zero", bus_rdata, 8'h00);

        // R7: write once, masked bits
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R7 first write masked", v, 8'hF3);
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R7 second write ignored", v, 8'hF3);

        // R6: bus write to force register has no effect
        wr(2'd1, 8'h01);
        check("R6 bus write no reset", sys_rst, 0);
        rd(2'd2, v); check("R6 bus write options unchanged", v, 8'hF3);
        // R3: status not writable
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R3 status not writable", v, 8'h03);
        // R6: debug write with bit0 clear
        dbgw(8'hFE);
        check("R6 debug bit0 clear no reset", sys_rst, 0);
        rd(2'd0, v); check("R6 debug bit0 clear status", v, 8'h03);

        // R6 / R8: debug force
        dbgw(8'h01);
        count_rst(n);
        check("R2 debug stretch length", n, STRETCH);
        rd(2'd0, v); check("R6 debug flag", v, 8'h20);
        rd(2'd2, v); check("R8 options restored", v, 8'hB0);

        // R2 / R3 / R9: extension and accumulation
        dbgw(8'h01);
        repeat (3) @(negedge clk);
        wr(2'd2, 8'h00);
        pulse_src(6);
        count_rst(n);
        check("R2 extension length", n, STRETCH);
        rd(2'd0, v); check("R3 accumulated flags", v, 8'h30);
        rd(2'd2, v); check("R9 write during reset ignored", v, 8'hB0);
        wr(2'd2, 8'h10);
        rd(2'd2, v); check("R8 write reopened after reset", v, 8'h10);

        // R3: simultaneous sources
        dbgw(8'h01);
        count_rst(n);
        @(negedge clk);
        wdog_req = 1'b1; clkloss_req = 1'b1;
        @(negedge clk);
        wdog_req = 1'b0; clkloss_req = 1'b0;
        count_rst(n);
        check("R3 simultaneous stretch", n, STRETCH);
        rd(2'd0, v); check("R3 simultaneous flags", v, 8'h14);

        // R4 / R5 / R6 / R3: sweep all enable configurations against all sources
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int s = 0; s < 8; s++) begin
                logic [7:0] optv;
                logic       qual;
                logic [7:0] flag;
                string      tag;
                dbgw(8'h01);
                count_rst(n);
                optv = {cfg[2], 1'b0, cfg[1], cfg[0], 4'b0000};
                wr(2'd2, optv);
                rd(2'd2, v); check("R7 sweep options write", v, optv);
                dbg_ena = (s == 3);
                case (s)
                    0: begin qual = 1'b1;    flag = 8'h08; tag = "R5 illegal opcode"; end
                    1: begin qual = !cfg[1]; flag = 8'h08; tag = "R5 stop instruction"; end
                    2: begin qual = 1'b1;    flag = 8'h08; tag = "R5 background debug off"; end
                    3: begin qual = 1'b0;    flag = 8'h08; tag = "R5 background debug on"; end
                    4: begin qual = cfg[2];  flag = 8'h04; tag = "R4 watchdog"; end
                    5: begin qual = cfg[0];  flag = 8'h02; tag = "R4 low voltage"; end
                    6: begin qual = 1'b1;    flag = 8'h10; tag = "R3 clock loss"; end
                    default: begin qual = 1'b1; flag = 8'h20; tag = "R6 debug force"; end
                endcase
                pulse_src(s);
                check({tag, " sys_rst"}, sys_rst, qual);
                if (qual) begin
                    count_rst(n);
                    check({tag, " R2 length"}, n, STRETCH);
                end
                rd(2'd0, v); check({tag, " status"}, v, qual ? flag : 8'h20);
                rd(2'd2, v); check({tag, " R8 options"}, v, qual ? 8'hB0 : optv);
                dbg_ena = 1'b0;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule